// File: doc/BRIEF.md
# SPI In-System Programming Command Slave

This block is the target end of a serial programming link. While its programming-mode input is held high, it acts as an SPI slave. It collects fixed 24-bit command frames from MOSI and carries them out against two on-chip byte arrays: a code store and a data store. It also keeps a small lock register. The host must first send an unlock frame. After that it can clear both arrays at once, write or read single bytes in either array, and program lock bits. Read results come back on MISO during the last byte of the same frame.

Every byte write runs on its own for a fixed number of system-clock cycles. The target byte reads as erased from the moment the frame is accepted, and the new value lands when the count expires. A host learns that a write has finished by reading the location it just wrote. While the write is pending, bit 7 of the result is inverted. The true byte returns once the write is complete. SCK, MOSI and the mode input all enter through two-flop synchronizers, and all logic runs on the system clock.

Top module: `isp_spi_slave`

## Requirements
- R1: After system reset, MISO is 0, busy is 0 and all three lock bits read 1.
- R2: Until a frame with first byte 0xAC and second byte 0x53 has been received in programming mode, every other frame is ignored: writes start no busy period and reads return 0x00.
- R3: A chip-erase frame (first byte 0xAC, second byte bits 2:0 = 100) sets every byte of both arrays to 0xFF, returns all lock bits to 1 and holds busy high while it runs.
- R4: Code write uses first byte {A[12:8],010} and code read uses {A[12:8],001}, with A[7:0] as the second byte. The third byte of a write is stored, and a read shifts the addressed byte out during the third byte. Only the low CODE_AW address bits select the code location.
- R5: Data write uses first byte {00,A[10:8],110} and data read uses {00,A[10:8],101}. These access an array separate from the code array.
- R6: A completed write leaves exactly the new byte in place, whatever the old content was (the location is erased before it is stored).
- R7: While a write is pending, a read of that same location returns {~D[7],7'h7F}, where D is the byte being written. A read of any other location returns its stored content.
- R8: Busy rises within four clocks after the 24th SCK rising edge of an accepted write frame, and stays high for exactly WRITE_CYCLES clocks.
- R9: Write, erase and lock frames that complete while busy is high are dropped.
- R10: A lock frame (first byte 0xAC, second byte bits 2:0 = 111) clears lock_bits[2], [1] and [0] where second-byte bits 7, 6 and 5 are 0. A 1 leaves the bit unchanged, and only chip erase sets bits back to 1.
- R11: Taking the mode input low discards any partial frame and cancels the unlock. The next frame is then decoded from its first bit, and it is treated as not yet unlocked.
- R12: Bytes travel MSB first. MOSI is sampled at SCK rising edges, MISO changes after SCK falling edges, and MISO stays 0 outside the third byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| isp_mode | input | 1 | Programming mode; frames are only taken while high |
| sck | input | 1 | Serial clock from the host |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| busy | output | 1 | High while a self-timed write or chip erase runs |
| lock_bits | output | 3 | Lock register, 1 = unprogrammed |

## Verification
Each SCK edge passes through two synchronizer flops and one edge register before it takes effect. MISO therefore settles about three clocks after a falling edge, and the bench samples it twenty clocks later, just before the next rising edge. Busy and the lock register change no later than four clocks after the last rising edge of a frame. The bench checks them only after its frame task has finished, about forty clocks after that edge. To measure the busy length, the bench counts every clock edge at which busy is high. It compares the count with WRITE_CYCLES exactly. The polled-read checks are placed inside a 5000-cycle write window, because each frame takes about 1000 clocks.

// File: rtl/isp_pkg.sv
package isp_pkg;

    localparam int FRAME_BITS = 24;
    localparam int CNT_W      = 5;
    localparam int LOAD_BIT   = 16;

    localparam logic [7:0] KEY_BYTE    = 8'hAC;
    localparam logic [7:0] UNLOCK_BYTE = 8'h53;
    localparam logic [7:0] BLANK_BYTE  = 8'hFF;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_UNLOCK,
        OP_ERASE,
        OP_LOCK,
        OP_CODE_RD,
        OP_CODE_WR,
        OP_DATA_RD,
        OP_DATA_WR
    } isp_op_e;

    typedef struct packed {
        isp_op_e     op;
        logic [12:0] addr;
    } isp_cmd_t;

    typedef struct packed {
        logic [7:0] b1;
        logic [7:0] b2;
        logic [7:0] b3;
    } isp_frame_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WRITE,
        ST_ERASE
    } eng_state_e;

    function automatic isp_cmd_t decode_cmd(input logic [7:0] b1, input logic [7:0] b2);
        isp_cmd_t c;
        c.op   = OP_NONE;
        c.addr = {b1[7:3], b2};
        if (b1 == KEY_BYTE) begin
            if (b2 == UNLOCK_BYTE)        c.op = OP_UNLOCK;
            else if (b2[2:0] == 3'b100)   c.op = OP_ERASE;
            else if (b2[2:0] == 3'b111)   c.op = OP_LOCK;
        end else begin
            case (b1[2:0])
                3'b001: c.op = OP_CODE_RD;
                3'b010: c.op = OP_CODE_WR;
                3'b101: if (b1[7:6] == 2'b00) c.op = OP_DATA_RD;
                3'b110: if (b1[7:6] == 2'b00) c.op = OP_DATA_WR;
                default: c.op = OP_NONE;
            endcase
        end
        return c;
    endfunction

endpackage

// File: rtl/isp_sync.sv
module isp_sync #(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stage1;
    logic [WIDTH-1:0] stage2;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= d_i;
            stage2 <= stage1;
        end
    end

    assign q_o = stage2;
endmodule

// File: rtl/isp_frame_rx.sv
module isp_frame_rx
    import isp_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  mode_i,
    input  logic                  sck_i,
    input  logic                  mosi_i,
    input  logic [7:0]            rd_byte_i,
    output logic [15:0]           hdr_o,
    output logic                  frame_valid_o,
    output isp_frame_t            frame_o,
    output logic                  miso_o,
    output logic [CNT_W-1:0]      bit_cnt_o
);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(FRAME_BITS - 1);
    localparam logic [CNT_W-1:0] LOAD_CNT = CNT_W'(LOAD_BIT);

    logic                  sck_q;
    logic                  sck_rise;
    logic                  sck_fall;
    logic [CNT_W-1:0]      cnt;
    logic [FRAME_BITS-2:0] rx_sr;
    logic [7:0]            tx_sr;

    assign sck_rise = sck_i & ~sck_q;
    assign sck_fall = ~sck_i & sck_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q         <= 1'b0;
            cnt           <= '0;
            rx_sr         <= '0;
            tx_sr         <= '0;
            frame_valid_o <= 1'b0;
            frame_o       <= '0;
        end else begin
            sck_q         <= sck_i;
            frame_valid_o <= 1'b0;
            if (!mode_i) begin
                cnt   <= '0;
                rx_sr <= '0;
                tx_sr <= '0;
            end else begin
                if (sck_rise) begin
                    rx_sr <= {rx_sr[FRAME_BITS-3:0], mosi_i};
                    if (cnt == LAST_CNT) begin
                        cnt           <= '0;
                        frame_valid_o <= 1'b1;
                        frame_o       <= {rx_sr, mosi_i};
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                if (sck_fall) begin
                    if (cnt == LOAD_CNT) tx_sr <= rd_byte_i;
                    else                 tx_sr <= {tx_sr[6:0], 1'b0};
                end
            end
        end
    end

    assign hdr_o     = rx_sr[15:0];
    assign miso_o    = tx_sr[7];
    assign bit_cnt_o = cnt;
endmodule

// File: rtl/isp_mem_ctrl.sv
module isp_mem_ctrl
    import isp_pkg::*;
#(
    parameter int CODE_AW      = 11,
    parameter int DATA_AW      = 11,
    parameter int WRITE_CYCLES = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       mode_i,
    input  logic       frame_valid_i,
    input  isp_frame_t frame_i,
    input  logic [15:0] hdr_i,
    output logic [7:0] rd_byte_o,
    output logic       busy_o,
    output logic [2:0] lock_o,
    output logic       enabled_o,
    output logic       wr_active_o,
    output logic       er_active_o
);
    localparam int CODE_DEPTH = 1 << CODE_AW;
    localparam int DATA_DEPTH = 1 << DATA_AW;
    localparam int ER_AW      = (CODE_AW > DATA_AW) ? CODE_AW : DATA_AW;
    localparam int WCW        = (WRITE_CYCLES > 2) ? $clog2(WRITE_CYCLES) : 1;
    localparam logic [ER_AW-1:0] ER_LAST = '1;

    logic [7:0] code_mem [CODE_DEPTH];
    logic [7:0] data_mem [DATA_DEPTH];

    eng_state_e       state;
    logic             enabled;
    logic [2:0]       lock;
    logic [WCW-1:0]   wcnt;
    logic [ER_AW-1:0] er_idx;
    logic             pend_code;
    logic [12:0]      pend_addr;
    logic [7:0]       pend_data;

    isp_cmd_t cmd;
    isp_cmd_t rcmd;
    logic     cmd_ok;

    logic               code_we, data_we;
    logic [CODE_AW-1:0] code_wa;
    logic [DATA_AW-1:0] data_wa;
    logic [7:0]         code_wd, data_wd;
    logic               unused_bits;

    assign cmd    = decode_cmd(frame_i.b1, frame_i.b2);
    assign rcmd   = decode_cmd(hdr_i[15:8], hdr_i[7:0]);
    assign cmd_ok = frame_valid_i && enabled && mode_i;
    assign unused_bits = ^{rcmd.addr, pend_addr, cmd.addr};

    always_comb begin
        code_we = 1'b0;
        data_we = 1'b0;
        code_wa = cmd.addr[CODE_AW-1:0];
        data_wa = cmd.addr[DATA_AW-1:0];
        code_wd = BLANK_BYTE;
        data_wd = BLANK_BYTE;
        case (state)
            ST_IDLE: begin
                if (cmd_ok && cmd.op == OP_CODE_WR) code_we = 1'b1;
                if (cmd_ok && cmd.op == OP_DATA_WR) data_we = 1'b1;
            end
            ST_WRITE: begin
                if (wcnt == '0) begin
                    code_we = pend_code;
                    data_we = !pend_code;
                    code_wa = pend_addr[CODE_AW-1:0];
                    data_wa = pend_addr[DATA_AW-1:0];
                    code_wd = pend_data;
                    data_wd = pend_data;
                end
            end
            ST_ERASE: begin
                code_we = 1'b1;
                data_we = 1'b1;
                code_wa = er_idx[CODE_AW-1:0];
                data_wa = er_idx[DATA_AW-1:0];
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (code_we) code_mem[code_wa] <= code_wd;
        if (data_we) data_mem[data_wa] <= data_wd;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            enabled   <= 1'b0;
            lock      <= 3'b111;
            wcnt      <= '0;
            er_idx    <= '0;
            pend_code <= 1'b0;
            pend_addr <= '0;
            pend_data <= '0;
        end else begin
            if (!mode_i)
                enabled <= 1'b0;
            else if (frame_valid_i && cmd.op == OP_UNLOCK)
                enabled <= 1'b1;

            case (state)
                ST_IDLE: begin
                    if (cmd_ok) begin
                        case (cmd.op)
                            OP_CODE_WR, OP_DATA_WR: begin
                                pend_code <= (cmd.op == OP_CODE_WR);
                                pend_addr <= cmd.addr;
                                pend_data <= frame_i.b3;
                                wcnt      <= WCW'(WRITE_CYCLES - 1);
                                state     <= ST_WRITE;
                            end
                            OP_ERASE: begin
                                er_idx <= '0;
                                lock   <= 3'b111;
                                state  <= ST_ERASE;
                            end
                            OP_LOCK: lock <= lock & frame_i.b2[7:5];
                            default: ;
                        endcase
                    end
                end
                ST_WRITE: begin
                    if (wcnt == '0) state <= ST_IDLE;
                    else            wcnt  <= wcnt - 1'b1;
                end
                ST_ERASE: begin
                    if (er_idx == ER_LAST) state  <= ST_IDLE;
                    else                   er_idx <= er_idx + 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        rd_byte_o = 8'h00;
        if (enabled) begin
            case (rcmd.op)
                OP_CODE_RD: begin
                    if (state == ST_WRITE && pend_code &&
                        pend_addr[CODE_AW-1:0] == rcmd.addr[CODE_AW-1:0])
                        rd_byte_o = {~pend_data[7], 7'h7F};
                    else
                        rd_byte_o = code_mem[rcmd.addr[CODE_AW-1:0]];
                end
                OP_DATA_RD: begin
                    if (state == ST_WRITE && !pend_code &&
                        pend_addr[DATA_AW-1:0] == rcmd.addr[DATA_AW-1:0])
                        rd_byte_o = {~pend_data[7], 7'h7F};
                    else
                        rd_byte_o = data_mem[rcmd.addr[DATA_AW-1:0]];
                end
                default: rd_byte_o = 8'h00;
            endcase
        end
    end

    assign busy_o      = (state != ST_IDLE);
    assign lock_o      = lock;
    assign enabled_o   = enabled;
    assign wr_active_o = (state == ST_WRITE);
    assign er_active_o = (state == ST_ERASE);
endmodule

// File: rtl/isp_spi_slave.sv
module isp_spi_slave
    import isp_pkg::*;
#(
    parameter int CODE_AW      = 11,
    parameter int DATA_AW      = 11,
    parameter int WRITE_CYCLES = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       isp_mode,
    input  logic       sck,
    input  logic       mosi,
    output logic       miso,
    output logic       busy,
    output logic [2:0] lock_bits
);
    logic             mode_s, sck_s, mosi_s;
    logic [7:0]       rd_byte;
    logic [15:0]      hdr;
    logic             frame_valid;
    isp_frame_t       frame;
    logic [CNT_W-1:0] bit_cnt;
    logic             enabled, wr_active, er_active;

    isp_sync #(.WIDTH(3)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i ({isp_mode, sck, mosi}),
        .q_o ({mode_s, sck_s, mosi_s})
    );

    isp_frame_rx u_rx (
        .clk           (clk),
        .rst           (rst),
        .mode_i        (mode_s),
        .sck_i         (sck_s),
        .mosi_i        (mosi_s),
        .rd_byte_i     (rd_byte),
        .hdr_o         (hdr),
        .frame_valid_o (frame_valid),
        .frame_o       (frame),
        .miso_o        (miso),
        .bit_cnt_o     (bit_cnt)
    );

    isp_mem_ctrl #(
        .CODE_AW      (CODE_AW),
        .DATA_AW      (DATA_AW),
        .WRITE_CYCLES (WRITE_CYCLES)
    ) u_mem (
        .clk           (clk),
        .rst           (rst),
        .mode_i        (mode_s),
        .frame_valid_i (frame_valid),
        .frame_i       (frame),
        .hdr_i         (hdr),
        .rd_byte_o     (rd_byte),
        .busy_o        (busy),
        .lock_o        (lock_bits),
        .enabled_o     (enabled),
        .wr_active_o   (wr_active),
        .er_active_o   (er_active)
    );
endmodule

// File: rtl/isp_spi_slave_chk.sv
module isp_spi_slave_chk (
    input logic       clk,
    input logic       rst,
    input logic       mode_s,
    input logic       miso,
    input logic       busy,
    input logic [2:0] lock_bits,
    input logic       enabled,
    input logic [4:0] bit_cnt,
    input logic       er_active
);
    // R2: a busy period can only begin from an unlocked state
    p_busy_needs_unlock_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(enabled));

    // R10: a lock bit may return to 1 only as part of a chip erase
    p_lock_release_by_erase_r10: assert property (@(posedge clk) disable iff (rst)
        ((lock_bits & ~$past(lock_bits)) != 3'b000) |-> er_active);

    // R3: an erase starts with every lock bit at 1
    p_erase_restores_lock_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(er_active) |-> (lock_bits == 3'b111));

    // R12: MISO stays 0 during the first two bytes
    p_miso_window_r12: assert property (@(posedge clk) disable iff (rst)
        miso |-> (bit_cnt >= 5'd16 || bit_cnt == 5'd0));

    // R11: mode low drops the frame position and the unlock
    p_mode_low_clears_r11: assert property (@(posedge clk) disable iff (rst)
        !mode_s |=> (!enabled && bit_cnt == 5'd0));
endmodule

bind isp_spi_slave isp_spi_slave_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .mode_s    (mode_s),
    .miso      (miso),
    .busy      (busy),
    .lock_bits (lock_bits),
    .enabled   (enabled),
    .bit_cnt   (bit_cnt),
    .er_active (er_active)
);

// File: tb/isp_spi_slave_bench.sv
module isp_spi_slave_bench;
    localparam int WCYC = 5000;
    localparam int HALF = 20;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       isp_mode = 1'b0;
    logic       sck = 1'b0;
    logic       mosi = 1'b0;
    logic       miso;
    logic       busy;
    logic [2:0] lock_bits;

    int  n_checks = 0;
    int  n_fail   = 0;
    int  bcnt     = 0;
    bit  bcnt_clr = 1'b0;
    bit  quiet_err = 1'b0;
    bit  done     = 1'b0;

    always #5 clk = ~clk;

    isp_spi_slave #(.CODE_AW(11), .DATA_AW(11), .WRITE_CYCLES(WCYC)) u_isp_spi_slave (
        .clk       (clk),
        .rst       (rst),
        .isp_mode  (isp_mode),
        .sck       (sck),
        .mosi      (mosi),
        .miso      (miso),
        .busy      (busy),
        .lock_bits (lock_bits)
    );

    always @(posedge clk) begin
        if (bcnt_clr) bcnt <= 0;
        else if (busy) bcnt <= bcnt + 1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic [7:0] b1, input logic [7:0] b2, input logic [7:0] b3,
                        output logic [7:0] rd);
        logic [23:0] f;
        f  = {b1, b2, b3};
        rd = 8'h00;
        for (int i = 0; i < 24; i++) begin
            @(negedge clk) mosi = f[23-i];
            repeat (HALF) @(negedge clk);
            if (i >= 16) rd[23-i] = miso;
            else if (miso !== 1'b0) quiet_err = 1'b1;
            sck = 1'b1;
            repeat (HALF) @(negedge clk);
            sck = 1'b0;
        end
        repeat (HALF) @(negedge clk);
    endtask

    task automatic wait_idle(input string req);
        int k;
        k = 0;
        while (busy && k < 20000) begin
            @(negedge clk);
            k++;
        end
        chk(req, {31'd0, busy}, 32'd0);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 miso", {31'd0, miso}, 0);
        chk("R1 busy", {31'd0, busy}, 0);
        chk("R1 lock", {29'd0, lock_bits}, 32'h7);
    endtask

    task automatic t_locked();
        logic [7:0] r;
        isp_mode = 1'b1;
        repeat (10) @(negedge clk);
        xfer(8'h02, 8'h10, 8'h55, r);
        repeat (10) @(negedge clk);
        chk("R2 write ignored", {31'd0, busy}, 0);
        xfer(8'h01, 8'h10, 8'h00, r);
        chk("R2 read zero", {24'd0, r}, 0);
    endtask

    task automatic t_erase();
        logic [7:0] r;
        xfer(8'hAC, 8'h53, 8'h00, r);
        xfer(8'hAC, 8'h04, 8'h00, r);
        chk("R3 busy during erase", {31'd0, busy}, 1);
        wait_idle("R3 erase ends");
        xfer(8'h01, 8'h10, 8'h00, r);
        chk("R3 code blank", {24'd0, r}, 32'hFF);
        xfer(8'h2D, 8'h10, 8'h00, r);
        chk("R3 data blank", {24'd0, r}, 32'hFF);
        chk("R3 lock", {29'd0, lock_bits}, 32'h7);
    endtask

    task automatic t_code();
        logic [7:0] r;
        @(negedge clk) bcnt_clr = 1'b1;
        @(negedge clk) bcnt_clr = 1'b0;
        xfer(8'h2A, 8'hA5, 8'h3C, r);
        chk("R8 busy after write", {31'd0, busy}, 1);
        wait_idle("R8 write ends");
        chk("R8 busy length", bcnt, WCYC);
        xfer(8'h29, 8'hA5, 8'h00, r);
        chk("R4 code readback", {24'd0, r}, 32'h3C);
        xfer(8'h21, 8'hA5, 8'h00, r);
        chk("R4 high address bits", {24'd0, r}, 32'hFF);
        xfer(8'h2D, 8'hA5, 8'h00, r);
        chk("R5 arrays separate", {24'd0, r}, 32'hFF);
    endtask

    task automatic t_data();
        logic [7:0] r;
        xfer(8'h36, 8'hB3, 8'h81, r);
        wait_idle("R5 write ends");
        xfer(8'h35, 8'hB3, 8'h00, r);
        chk("R5 data readback", {24'd0, r}, 32'h81);
        xfer(8'h15, 8'hB3, 8'h00, r);
        chk("R5 data address", {24'd0, r}, 32'hFF);
    endtask

    task automatic t_poll();
        logic [7:0] r;
        xfer(8'h2A, 8'hA5, 8'hC3, r);
        xfer(8'h29, 8'hA5, 8'h00, r);
        chk("R7 polled pending", {24'd0, r}, 32'h7F);
        xfer(8'h21, 8'hA5, 8'h00, r);
        chk("R7 other location", {24'd0, r}, 32'hFF);
        xfer(8'h0A, 8'h23, 8'h00, r);
        chk("R9 busy still", {31'd0, busy}, 1);
        wait_idle("R7 write ends");
        xfer(8'h29, 8'hA5, 8'h00, r);
        chk("R6 overwrite", {24'd0, r}, 32'hC3);
        xfer(8'h09, 8'h23, 8'h00, r);
        chk("R9 dropped write", {24'd0, r}, 32'hFF);
    endtask

    task automatic t_lock();
        logic [7:0] r;
        xfer(8'hAC, 8'hA7, 8'h00, r);
        chk("R10 program LB2", {29'd0, lock_bits}, 32'h5);
        xfer(8'hAC, 8'h67, 8'h00, r);
        chk("R10 no unprogram", {29'd0, lock_bits}, 32'h1);
        xfer(8'hAC, 8'h04, 8'h00, r);
        chk("R3 erase restores lock", {29'd0, lock_bits}, 32'h7);
        wait_idle("R3 second erase ends");
    endtask

    task automatic t_abort();
        logic [7:0] r;
        xfer(8'h02, 8'hF0, 8'h5A, r);
        wait_idle("R11 write ends");
        for (int i = 0; i < 10; i++) begin
            @(negedge clk) mosi = 1'b1;
            repeat (HALF) @(negedge clk);
            sck = 1'b1;
            repeat (HALF) @(negedge clk);
            sck = 1'b0;
        end
        isp_mode = 1'b0;
        repeat (10) @(negedge clk);
        isp_mode = 1'b1;
        repeat (10) @(negedge clk);
        xfer(8'h01, 8'hF0, 8'h00, r);
        chk("R11 unlock cleared", {24'd0, r}, 0);
        xfer(8'hAC, 8'h53, 8'h00, r);
        xfer(8'h01, 8'hF0, 8'h00, r);
        chk("R11 realigned", {24'd0, r}, 32'h5A);
        chk("R12 miso quiet", {31'd0, quiet_err}, 0);
    endtask

    initial begin
        t_reset();
        t_locked();
        t_erase();
        t_code();
        t_data();
        t_poll();
        t_lock();
        t_abort();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (190000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule